// File: doc/BRIEF.md
# Subword Mix and Permute Unit

This block rearranges the 16-bit and 32-bit pieces of 64-bit operands, with no arithmetic and no memory access. Two-operand interleave operations build a result from alternating halfwords of A and B, or from matching 32-bit halves of A and B. A one-operand halfword permute fills each destination lane from any source lane of A, so one source lane may appear in several destination lanes.

A request is presented with `validIn` high, together with the operands, the operation code and the permute selector. The result is registered and appears one clock later with `validOut` high. A new request may be accepted on every clock. Between requests the result register keeps its last value.

Lanes are counted from the top of the word. Lane 1 is bits 63:48, lane 2 is bits 47:32, lane 3 is bits 31:16 and lane 4 is bits 15:0. In the text below, aN and bN are lane N of A and of B.

Top module: `subword_mix_unit`

## Requirements
- R1: While `rst` is high, and after the clock edge that samples it high, `validOut` is 0 and `result` is all zeros, whatever the other inputs are.
- R2: `validOut` is high in exactly the cycle after each clock edge that samples `validIn` high. Back-to-back requests each produce their own result, one clock after their own request.
- R3: After an edge that samples `validIn` low, `result` keeps its previous value and `validOut` is 0.
- R4: Operation code 0 (halfword interleave, upper picks) gives the lanes, from lane 1 down to lane 4, a1, b1, a3, b3.
- R5: Operation code 1 (halfword interleave, lower picks) gives, from lane 1 down to lane 4, a2, b2, a4, b4.
- R6: Operation code 2 (word interleave, upper) gives bits 63:32 equal to A bits 63:32 and bits 31:0 equal to B bits 63:32.
- R7: Operation code 3 (word interleave, lower) gives bits 63:32 equal to A bits 31:0 and bits 31:0 equal to B bits 31:0.
- R8: Operation code 4 (halfword permute) fills each destination lane from one lane of A. The 8-bit selector holds one 2-bit field per destination lane. Bits 7:6 serve lane 1, bits 5:4 serve lane 2, bits 3:2 serve lane 3 and bits 1:0 serve lane 4. A field value v picks source lane v+1.
- R9: For operation code 4, the value of B has no effect on `result`.
- R10: The permute can repeat a source lane in any destination lanes, including all four, for every one of the 256 selector values.
- R11: Operation codes 5, 6 and 7 produce an all-zero `result`, with `validOut` asserted as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Request strobe |
| opSel | input | 3 | Operation code (0 to 4 defined, see R4 to R8) |
| opA | input | 64 | Operand A, also the permute source |
| opB | input | 64 | Operand B, not used by the permute |
| permSel | input | 8 | Permute selector, four 2-bit source fields |
| validOut | output | 1 | Result strobe, one cycle after `validIn` |
| result | output | 64 | Registered rearranged word |

## Verification
Every result and its `validOut` strobe are due after the first rising edge that samples the request, and no sooner or later. The bench drives each request on a falling edge. It checks the outputs on the next falling edge, which lies half a period after the edge that registers them. In the permute sweep, all 256 selectors are issued back to back. Each cycle's check therefore covers the request made one cycle before it, and the check one cycle later shows the newer request did not disturb it. Hold checks are made over several idle cycles after the last request, at the same half-period offset.

// File: rtl/subword_mix_pkg.sv
package subword_mix_pkg;

  typedef enum logic [2:0] {
    OP_MIXH_HI = 3'd0,
    OP_MIXH_LO = 3'd1,
    OP_MIXW_HI = 3'd2,
    OP_MIXW_LO = 3'd3,
    OP_PERMH   = 3'd4
  } mixOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic selMixH;    // halfword interleave
    logic selMixW;    // word interleave
    logic selPerm;    // halfword permute of A
    logic pickRight;  // lower picks for the interleaves
  } mixStrobes_t;

endpackage

// File: rtl/subword_mix_ctrl.sv
module subword_mix_ctrl
  import subword_mix_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        validIn,
  input  logic [2:0]  opSel,
  output mixStrobes_t stb,
  output logic        validOut
);

  always_comb begin
    stb           = '0;
    stb.load      = validIn;
    unique case (opSel)
      OP_MIXH_HI: stb.selMixH = 1'b1;
      OP_MIXH_LO: begin stb.selMixH = 1'b1; stb.pickRight = 1'b1; end
      OP_MIXW_HI: stb.selMixW = 1'b1;
      OP_MIXW_LO: begin stb.selMixW = 1'b1; stb.pickRight = 1'b1; end
      OP_PERMH:   stb.selPerm = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);
  assert_no_spurious_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);

endmodule

// File: rtl/subword_mix_datapath.sv
module subword_mix_datapath
  import subword_mix_pkg::*;
#(
  parameter  int LANE_W    = 16,
  parameter  int NUM_LANES = 4,
  localparam int DW        = LANE_W * NUM_LANES,
  localparam int IW        = $clog2(NUM_LANES),
  localparam int PSW       = IW * NUM_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  mixStrobes_t      stb,
  input  logic [DW-1:0]    opA,
  input  logic [DW-1:0]    opB,
  input  logic [PSW-1:0]   permSel,
  output logic [DW-1:0]    result
);

  localparam int HALF = NUM_LANES / 2;

  // Lane 0 of each array is the most significant lane
  logic [LANE_W-1:0] aLane [NUM_LANES];
  logic [LANE_W-1:0] bLane [NUM_LANES];
  logic [DW-1:0]     nextRes;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_unpack
    assign aLane[i] = opA[DW-1-i*LANE_W -: LANE_W];
    assign bLane[i] = opB[DW-1-i*LANE_W -: LANE_W];
  end

  for (genvar d = 0; d < NUM_LANES; d++) begin : g_lane
    localparam int PAIR = (d / 2) * 2;
    logic [LANE_W-1:0] hLane, wLane, pLane;
    logic [IW-1:0]     srcIdx;

    // Halfword interleave: even lanes from A, odd lanes from B
    if (d % 2 == 0) begin : g_hA
      assign hLane = stb.pickRight ? aLane[PAIR+1] : aLane[PAIR];
    end else begin : g_hB
      assign hLane = stb.pickRight ? bLane[PAIR+1] : bLane[PAIR];
    end

    // Word interleave: upper half from A, lower half from B
    if (d < HALF) begin : g_wA
      assign wLane = stb.pickRight ? aLane[d+HALF] : aLane[d];
    end else begin : g_wB
      assign wLane = stb.pickRight ? bLane[d] : bLane[d-HALF];
    end

    // Permute: field for destination d sits at the top for d = 0
    assign srcIdx = permSel[PSW-1-d*IW -: IW];
    assign pLane  = aLane[srcIdx];

    assign nextRes[DW-1-d*LANE_W -: LANE_W] =
        stb.selPerm ? pLane :
        stb.selMixW ? wLane :
        stb.selMixH ? hLane : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)           result <= '0;
    else if (stb.load) result <= nextRes;
  end

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> $stable(result));

  assert_mixh_top_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (stb.load && stb.selMixH && !stb.pickRight)
      |=> result[DW-1 -: LANE_W] == $past(opA[DW-1 -: LANE_W]));

  assert_mixw_low_half_R7: assert property (@(posedge clk) disable iff (rst)
    (stb.load && stb.selMixW && stb.pickRight)
      |=> result[DW/2-1:0] == $past(opB[DW/2-1:0]));

  assert_perm_broadcast_R10: assert property (@(posedge clk) disable iff (rst)
    (stb.load && stb.selPerm && permSel == '0)
      |=> result == {NUM_LANES{$past(opA[DW-1 -: LANE_W])}});

  assert_undefined_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (stb.load && !stb.selPerm && !stb.selMixW && !stb.selMixH)
      |=> result == '0);

endmodule

// File: rtl/subword_mix_unit.sv
module subword_mix_unit
  import subword_mix_pkg::*;
#(
  parameter  int LANE_W    = 16,
  parameter  int NUM_LANES = 4,
  localparam int DW        = LANE_W * NUM_LANES,
  localparam int PSW       = $clog2(NUM_LANES) * NUM_LANES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           validIn,
  input  logic [2:0]     opSel,
  input  logic [DW-1:0]  opA,
  input  logic [DW-1:0]  opB,
  input  logic [PSW-1:0] permSel,
  output logic           validOut,
  output logic [DW-1:0]  result
);

  mixStrobes_t stb;

  subword_mix_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .opSel    (opSel),
    .stb      (stb),
    .validOut (validOut)
  );

  subword_mix_datapath #(
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES)
  ) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .opA     (opA),
    .opB     (opB),
    .permSel (permSel),
    .result  (result)
  );

endmodule

// File: tb/test_subword_mix_unit.sv
`timescale 1ns/1ps
module test_subword_mix_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        validIn = 1'b0;
  logic [2:0]  opSel = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [7:0]  permSel = '0;
  logic        validOut;
  logic [63:0] result;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  subword_mix_unit i_subword_mix_unit (
    .clk(clk), .rst(rst), .validIn(validIn), .opSel(opSel),
    .opA(opA), .opB(opB), .permSel(permSel),
    .validOut(validOut), .result(result)
  );

  function automatic logic [15:0] ln(logic [63:0] x, int i);  // i = 1..4
    return 16'((x >> (16 * (4 - i))) & 64'hFFFF);
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a,
                                        logic [63:0] b, logic [7:0] s);
    case (op)
      3'd0: return {ln(a,1), ln(b,1), ln(a,3), ln(b,3)};
      3'd1: return {ln(a,2), ln(b,2), ln(a,4), ln(b,4)};
      3'd2: return {a[63:32], b[63:32]};
      3'd3: return {a[31:0], b[31:0]};
      3'd4: return {ln(a, int'(s[7:6]) + 1), ln(a, int'(s[5:4]) + 1),
                    ln(a, int'(s[3:2]) + 1), ln(a, int'(s[1:0]) + 1)};
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [7:0] s);
    validIn = 1'b1; opSel = op; opA = a; opB = b; permSel = s;
  endtask

  // One request, checked one cycle later; leaves validIn low
  task automatic single(string tag, logic [2:0] op, logic [63:0] a,
                        logic [63:0] b, logic [7:0] s);
    @(negedge clk); drive(op, a, b, s);
    @(negedge clk); validIn = 1'b0;
    check({tag, " R2 valid"}, 64'(validOut), 64'd1);
    check(tag, result, model(op, a, b, s));
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] lastExp;
    // R1: reset holds outputs at zero even with a request presented
    @(negedge clk); drive(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    @(negedge clk); @(negedge clk);
    check("R1 validOut", 64'(validOut), 64'd0);
    check("R1 result", result, 64'd0);
    validIn = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", 64'(validOut), 64'd0);

    // R4..R7 over several operand patterns
    for (int k = 0; k < 6; k++) begin
      logic [63:0] a, b;
      a = {16'hA100 + 16'(k), 16'hA200 + 16'(k), 16'hA300 + 16'(k), 16'hA400 + 16'(k)};
      b = {16'hB100 + 16'(k), 16'hB200 + 16'(k), 16'hB300 + 16'(k), 16'hB400 + 16'(k)};
      if (k == 4) begin a = 64'hDEAD_BEEF_0123_4567; b = 64'h89AB_CDEF_FEDC_BA98; end
      if (k == 5) begin a = 64'hFFFF_0000_FFFF_0000; b = 64'h0000_FFFF_0000_FFFF; end
      single("R4 mix halfword upper", 3'd0, a, b, 8'h00);
      single("R5 mix halfword lower", 3'd1, a, b, 8'h00);
      single("R6 mix word upper",     3'd2, a, b, 8'h00);
      single("R7 mix word lower",     3'd3, a, b, 8'h00);
    end

    // R11: undefined codes give zero
    for (int op = 5; op < 8; op++)
      single("R11 undefined op", 3'(op), 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 8'hE4);

    // R8, R10: all 256 selectors back to back; R2 back-to-back timing
    lastExp = '0;
    for (int s = 0; s < 256; s++) begin
      @(negedge clk);
      if (s > 0) begin
        check("R2 back-to-back valid", 64'(validOut), 64'd1);
        check("R8 R10 permute", result, lastExp);
      end
      drive(3'd4, 64'h1111_2222_3333_4444, 64'(s) * 64'h0101_0101_0101_0101, 8'(s));
      lastExp = model(3'd4, 64'h1111_2222_3333_4444, 64'h0, 8'(s));
    end
    @(negedge clk); validIn = 1'b0;
    check("R8 R10 permute last", result, lastExp);

    // R9: B varied under a fixed selector, result must not change
    for (int v = 0; v < 4; v++) begin
      logic [63:0] bv;
      bv = (v == 0) ? 64'h0 : (v == 1) ? 64'hFFFF_FFFF_FFFF_FFFF :
           (v == 2) ? 64'h5A5A_A5A5_1234_8765 : 64'h8000_0001_7FFF_FFFE;
      single("R9 B ignored for permute", 3'd4, 64'hCAFE_F00D_BEEF_0042, bv, 8'h1B);
    end

    // R3: hold while idle
    lastExp = model(3'd4, 64'hCAFE_F00D_BEEF_0042, 64'h0, 8'h1B);
    for (int i = 0; i < 3; i++) begin
      opA = ~opA; opB = ~opB; opSel = 3'd0; permSel = ~permSel;
      @(negedge clk);
      check("R3 validOut low when idle", 64'(validOut), 64'd0);
      check("R3 result held", result, lastExp);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule